// File: doc/BRIEF.md
# Serial Control Port with Double-Buffered Channel Volume

This block is the control front end of a stereo audio converter. A host loads 16-bit control words over a three-wire serial link: a data line, a shift clock and a load strobe, qualified by an active-low select. The port brings all four link lines into the system clock domain, gathers the bits MSB first, and on each load decodes the word into one of four 9-bit control registers. Two of these hold the left and right volume codes and two hold converter and audio-format settings.

Volume writes are double-buffered. Each channel has a staging register. A write that carries the commit flag schedules every staged code, including the one in that write, for release to both channel outputs together on the next audio sample strobe. This keeps the left and right steps in the same sample. A link bit can make the right output follow the left code. A power-down bit returns every setting to its default. After power-down is released, the block marks the next sixteen samples to be discarded.

Top module: `vol_ctrl_port`

## Requirements
- R1: After reset both volume outputs are 0xFF, every decoded control output is 0, and the discard flag is low.
- R2: A word is the last 16 bits sampled on rising edges of the shift clock, MSB first. It is taken only on a rising edge of the load strobe while select is low. With select high the load has no effect.
- R3: Word bits 15:9 are the address and bits 8:0 the data. Address values 0 to 3 pick left volume, right volume, converter control and format control. A word whose bits 15:11 are not all zero is discarded.
- R4: A volume write (address 0 or 1) with data bit 8 clear changes only that channel's staging register. The volume outputs do not change, even across sample strobes.
- R5: A volume write with data bit 8 set makes both outputs take their staged codes, including the one just written, on the next sample strobe and not before. The commit flag is not stored.
- R6: Converter control fields: bit 0 soft mute, bit 1 de-emphasis, bit 2 power-down, bits 5:3 word-length code.
- R7: Format control fields: bit 0 I2S select, bit 1 word-clock polarity, bit 2 volume link, bit 4 phase reverse, bit 5 bit-clock polarity, bit 8 zero-detect enable.
- R8: While link is set, the right output takes the left channel's code at each sample strobe, with no commit write. When link is cleared, the right code returns at the next strobe.
- R9: Writing power-down as 1 returns all volume, staging and control state to reset values. While power-down holds, writes to the other addresses are ignored.
- R10: Clearing power-down raises the discard flag. The flag stays high for exactly 16 sample strobes.
- R11: Volume codes pass unaltered: 0xFF is 0 dB, each step down adds 0.5 dB, and 0x00 is mute. Every one of the 256 codes reaches the output as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; a rising edge takes the word |
| ser_sel_n | input | 1 | Active-low select |
| sample_tick | input | 1 | One-cycle pulse per audio sample |
| vol_left | output | 8 | Effective left volume code |
| vol_right | output | 8 | Effective right volume code |
| soft_mute | output | 1 | Soft mute |
| deemph_en | output | 1 | De-emphasis enable |
| power_down | output | 1 | Power-down state |
| word_len | output | 3 | Word-length code |
| fmt_i2s | output | 1 | I2S format select |
| wclk_inv | output | 1 | Word-clock polarity |
| vol_link | output | 1 | Right follows left volume |
| phase_rev | output | 1 | Output phase reverse |
| bclk_inv | output | 1 | Bit-clock polarity |
| zero_det_en | output | 1 | Zero-detect enable |
| discard_sample | output | 1 | Current sample should be ignored |

## Verification
The volume path is swept over all 256 codes. Each step stages a left code and then commits a complementary right code, so a swapped channel, a dropped staging value or a one-off code shows up. Single writes with and without the commit flag are checked before and after a strobe, which separates early release from missing release. Both control registers are swept over every combination of their fields to catch misplaced bits. Separate patterns exercise a deselected load, an address with an upper bit set, a word preceded by extra bits, link on and off, and the count of discarded samples after power-down.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 9;
  localparam int VOL_W  = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_VOL_L = 2'd0,
    SEL_VOL_R = 2'd1,
    SEL_CONV  = 2'd2,
    SEL_FMT   = 2'd3
  } sel_e;

  typedef struct packed {
    logic       zero_det;
    logic       bclk_inv;
    logic       phase_rev;
    logic       link;
    logic       wclk_inv;
    logic       i2s;
  } fmt_t;

  typedef struct packed {
    logic [2:0] wlen;
    logic       deemph;
    logic       mute;
  } conv_t;
endpackage

// File: rtl/vcp_sync_edge.sv
module vcp_sync_edge #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
          prev  <= 1'b0;
        end else begin
          chain <= {chain[STAGES-2:0], async_in[g]};
          prev  <= chain[STAGES-1];
        end
      end
      assign level[g] = chain[STAGES-1];
      assign rise[g]  = chain[STAGES-1] & ~prev;
    end
  endgenerate
endmodule

// File: rtl/vcp_shift.sv
module vcp_shift
  import vcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              load_rise,
  input  logic              sel_n,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg       <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      if (shift_en) sreg <= {sreg[WORD_W-2:0], bit_in};
      word_valid <= load_rise & ~sel_n;
      if (load_rise & ~sel_n) word <= sreg;
    end
  end

  // R2: a load edge yields at most a single-cycle commit pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
endmodule

// File: rtl/vcp_regs.sv
module vcp_regs
  import vcp_pkg::*;
#(
  parameter int IGNORE_N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  input  logic              tick,
  output logic [VOL_W-1:0]  vol_l,
  output logic [VOL_W-1:0]  vol_r,
  output conv_t             conv,
  output logic              pd,
  output fmt_t              fmt,
  output logic              discard
);
  localparam int ADDR_W = WORD_W - DATA_W;
  localparam int CNT_W  = $clog2(IGNORE_N + 1);
  localparam logic [VOL_W-1:0] VOL_DEF = '1;

  logic [DATA_W-1:0] d;
  logic              hit, wr_l, wr_r, wr_c, wr_f, upd_wr, pd_set, pd_clr, pd_force;
  sel_e              sel;
  logic [VOL_W-1:0]  pre_l, pre_r, act_l, act_r, nxt_l, nxt_r;
  logic              pend;
  logic [CNT_W-1:0]  cnt;

  assign d      = word[DATA_W-1:0];
  assign sel    = sel_e'(word[DATA_W+SEL_W-1:DATA_W]);
  assign hit    = word_valid && (word[WORD_W-1:DATA_W+SEL_W] == '0);
  assign wr_l   = hit && sel == SEL_VOL_L;
  assign wr_r   = hit && sel == SEL_VOL_R;
  assign wr_c   = hit && sel == SEL_CONV;
  assign wr_f   = hit && sel == SEL_FMT;
  assign upd_wr = (wr_l | wr_r) & d[8];
  assign pd_set = wr_c & d[2];
  assign pd_clr = wr_c & ~d[2];
  assign pd_force = pd | pd_set;
  assign nxt_l  = pend ? pre_l : act_l;
  assign nxt_r  = pend ? pre_r : act_r;

  // converter control and power-down state
  always_ff @(posedge clk) begin
    if (rst) begin
      pd   <= 1'b0;
      conv <= '0;
    end else if (wr_c) begin
      pd   <= d[2];
      conv <= d[2] ? conv_t'('0) : conv_t'({d[5:3], d[1], d[0]});
    end
  end

  // volume staging, release and format control
  always_ff @(posedge clk) begin
    if (rst || pd_force) begin
      pre_l <= VOL_DEF;
      pre_r <= VOL_DEF;
      act_l <= VOL_DEF;
      act_r <= VOL_DEF;
      vol_r <= VOL_DEF;
      pend  <= 1'b0;
      fmt   <= '0;
    end else begin
      if (wr_l) pre_l <= d[VOL_W-1:0];
      if (wr_r) pre_r <= d[VOL_W-1:0];
      if (wr_f) fmt <= '{zero_det: d[8], bclk_inv: d[5], phase_rev: d[4],
                         link: d[2], wclk_inv: d[1], i2s: d[0]};
      pend <= (pend & ~tick) | upd_wr;
      if (tick) begin
        act_l <= nxt_l;
        act_r <= nxt_r;
        vol_r <= fmt.link ? nxt_l : nxt_r;
      end
    end
  end
  assign vol_l = act_l;

  // discard window after power-down release
  always_ff @(posedge clk) begin
    if (rst || pd_set) cnt <= '0;
    else if (pd && pd_clr) cnt <= CNT_W'(IGNORE_N);
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end
  assign discard = (cnt != '0);

  // R4: outputs move only at a sample strobe (or on entering power-down)
  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (!tick && !pd_set) |=> ($stable(vol_l) && $stable(vol_r)));
  // R5: a pending release is consumed by the strobe
  a_r5_release_consumed: assert property (@(posedge clk) disable iff (rst)
    (tick && !upd_wr && !pd_force) |=> !pend);
  // R8: linked right channel equals left after a strobe
  a_r8_link_follows: assert property (@(posedge clk) disable iff (rst)
    (tick && fmt.link && !pd_force) |=> (vol_r == vol_l));
  // R9: power-down holds defaults
  a_r9_pd_defaults: assert property (@(posedge clk) disable iff (rst)
    pd |-> (vol_l == VOL_DEF && vol_r == VOL_DEF && !pend && fmt == '0));
  // R10: discard window never exceeds its length
  a_r10_window_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(IGNORE_N));
endmodule

// File: rtl/vol_ctrl_port.sv
module vol_ctrl_port
  import vcp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IGNORE_N    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_load,
  input  logic       ser_sel_n,
  input  logic       sample_tick,
  output logic [7:0] vol_left,
  output logic [7:0] vol_right,
  output logic       soft_mute,
  output logic       deemph_en,
  output logic       power_down,
  output logic [2:0] word_len,
  output logic       fmt_i2s,
  output logic       wclk_inv,
  output logic       vol_link,
  output logic       phase_rev,
  output logic       bclk_inv,
  output logic       zero_det_en,
  output logic       discard_sample
);
  localparam int NLINES = 4;

  logic [NLINES-1:0] lvl, rise;
  logic              word_valid;
  logic [WORD_W-1:0] word;
  conv_t             conv;
  fmt_t              fmt;

  vcp_sync_edge #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({ser_sel_n, ser_load, ser_dat, ser_clk}),
    .level(lvl), .rise(rise)
  );

  vcp_shift u_shift (
    .clk(clk), .rst(rst),
    .shift_en(rise[0]), .bit_in(lvl[1]),
    .load_rise(rise[2]), .sel_n(lvl[3]),
    .word_valid(word_valid), .word(word)
  );

  vcp_regs #(.IGNORE_N(IGNORE_N)) u_regs (
    .clk(clk), .rst(rst),
    .word_valid(word_valid), .word(word), .tick(sample_tick),
    .vol_l(vol_left), .vol_r(vol_right),
    .conv(conv), .pd(power_down), .fmt(fmt),
    .discard(discard_sample)
  );

  assign soft_mute   = conv.mute;
  assign deemph_en   = conv.deemph;
  assign word_len    = conv.wlen;
  assign fmt_i2s     = fmt.i2s;
  assign wclk_inv    = fmt.wclk_inv;
  assign vol_link    = fmt.link;
  assign phase_rev   = fmt.phase_rev;
  assign bclk_inv    = fmt.bclk_inv;
  assign zero_det_en = fmt.zero_det;
endmodule

// File: tb/sim_vol_ctrl_port.sv
module sim_vol_ctrl_port;
  logic clk = 0, rst = 1;
  logic ser_clk = 0, ser_dat = 0, ser_load = 0, ser_sel_n = 1, sample_tick = 0;
  logic [7:0] vol_left, vol_right;
  logic soft_mute, deemph_en, power_down, fmt_i2s, wclk_inv, vol_link;
  logic phase_rev, bclk_inv, zero_det_en, discard_sample;
  logic [2:0] word_len;
  int checks = 0, failures = 0;
  logic done = 0;

  always #10 clk = ~clk;

  vol_ctrl_port u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .ser_sel_n(ser_sel_n), .sample_tick(sample_tick),
    .vol_left(vol_left), .vol_right(vol_right), .soft_mute(soft_mute),
    .deemph_en(deemph_en), .power_down(power_down), .word_len(word_len),
    .fmt_i2s(fmt_i2s), .wclk_inv(wclk_inv), .vol_link(vol_link),
    .phase_rev(phase_rev), .bclk_inv(bclk_inv), .zero_det_en(zero_det_en),
    .discard_sample(discard_sample)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n, input logic sel_n);
    ser_sel_n = sel_n;
    wait_clk(3);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      wait_clk(3);
      ser_clk = 1;
      wait_clk(3);
      ser_clk = 0;
    end
    wait_clk(3);
    ser_load = 1;
    wait_clk(4);
    ser_load = 0;
    wait_clk(2);
    ser_sel_n = 1;
    wait_clk(2);
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] dat);
    send_bits({16'h0, 5'b0, a, dat}, 16, 1'b0);
  endtask

  task automatic tick();
    @(negedge clk) sample_tick = 1;
    @(negedge clk) sample_tick = 0;
    wait_clk(2);
  endtask

  initial begin
    wait_clk(3);
    rst = 0;
    wait_clk(2);
    // R1 reset state
    chk("R1 vol", {vol_left, vol_right}, 16'hFFFF);
    chk("R1 ctrl", {soft_mute, deemph_en, power_down, word_len, fmt_i2s, wclk_inv,
                    vol_link, phase_rev, bclk_inv, zero_det_en, discard_sample}, 0);

    // R4 staged write without commit
    wr(2'd0, 9'h055);
    chk("R4 no change before tick", vol_left, 8'hFF);
    tick();
    chk("R4 no change after tick", {vol_left, vol_right}, 16'hFFFF);

    // R5 commit releases both staged codes at next strobe only
    wr(2'd1, 9'h1AA);
    chk("R5 not before tick", {vol_left, vol_right}, 16'hFFFF);
    tick();
    chk("R5 released", {vol_left, vol_right}, 16'h55AA);

    // R3 upper address bit set: discarded
    send_bits({16'h0, 16'h0800 | 16'h0110}, 16, 1'b0);
    tick();
    chk("R3 bad address discarded", {vol_left, vol_right}, 16'h55AA);

    // R2 deselected load ignored
    send_bits({16'h0, 16'h0101}, 16, 1'b1);
    tick();
    chk("R2 deselected ignored", {vol_left, vol_right}, 16'h55AA);

    // R2 extra leading bits: last 16 used
    send_bits({12'h0, 4'hF, 16'h0133}, 20, 1'b0);
    tick();
    chk("R2 last sixteen bits", {vol_left, vol_right}, 16'h33AA);

    // R6 converter control sweep (power-down bit kept clear)
    for (int v = 0; v < 32; v++) begin
      logic [2:0] wl;
      wl = v[4:2];
      wr(2'd2, {3'b0, wl, 1'b0, v[1], v[0]});
      chk("R6 conv fields", {soft_mute, deemph_en, word_len, power_down},
          {v[0], v[1], wl, 1'b0});
    end
    wr(2'd2, 9'h000);

    // R7 format control sweep (volume codes unaffected while link not strobed)
    for (int v = 0; v < 64; v++) begin
      wr(2'd3, {v[5], 2'b0, v[4], v[3], 1'b0, v[2], v[1], v[0]});
      chk("R7 fmt fields", {zero_det_en, bclk_inv, phase_rev, vol_link, wclk_inv, fmt_i2s},
          v[5:0]);
    end
    wr(2'd3, 9'h000);

    // R8 link
    wr(2'd0, 9'h030);
    wr(2'd1, 9'h190);
    tick();
    chk("R8 setup", {vol_left, vol_right}, 16'h3090);
    wr(2'd3, 9'h004);
    chk("R8 not before tick", vol_right, 8'h90);
    tick();
    chk("R8 right follows left", vol_right, 8'h30);
    wr(2'd3, 9'h000);
    tick();
    chk("R8 right restored", vol_right, 8'h90);

    // R11/R5 sweep over every code
    for (int c = 0; c < 256; c++) begin
      wr(2'd0, {1'b0, 8'(c)});
      wr(2'd1, {1'b1, 8'(255 - c)});
      tick();
      chk("R11 code sweep", {vol_left, vol_right}, {8'(c), 8'(255 - c)});
    end

    // R9 power-down
    wr(2'd0, 9'h140);
    tick();
    wr(2'd3, 9'h013);
    wr(2'd2, 9'h001);
    wr(2'd2, 9'h004);
    chk("R9 pd state", {power_down, soft_mute, vol_left, vol_right}, {2'b10, 16'hFFFF});
    chk("R9 fmt cleared", {fmt_i2s, wclk_inv, phase_rev}, 0);
    wr(2'd0, 9'h120);
    tick();
    chk("R9 writes ignored", vol_left, 8'hFF);

    // R10 discard window
    wr(2'd2, 9'h000);
    chk("R10 discard raised", {power_down, discard_sample}, 2'b01);
    for (int i = 0; i < 15; i++) tick();
    chk("R10 still after 15", discard_sample, 1'b1);
    tick();
    chk("R10 cleared after 16", discard_sample, 1'b0);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule